// File: doc/BRIEF.md
# Opcode-Aware Two-Phase Execute Stage

This execute stage sits between decode and writeback in a simple in-order pipeline. Operations with a long critical path, such as a 32-bit add, can take two clock cycles instead of one. That lets the supply voltage drop while the clock period stays the same. Short logical operations still finish in one cycle. An operation is accepted on every cycle and the input never stalls.

Each opcode has a one-bit latency entry in a small table. The table is read as the operation is accepted. When a timing-error pulse names an opcode, that opcode's entry is raised to two cycles, and it never comes back down.

A mode input selects one of two modes:
- **Low-power mode:** the table decides each operation's latency, and a long add is split into two halves across two registers.
- **High-speed mode:** every operation completes in one stage.

Results always leave in program order. When a one-cycle result would collide with an older two-cycle result, the younger result waits one cycle in the second execute register.

Top module: `exec_stage`

## Requirements
- R1: In low-power mode, an operation whose table entry is two cycles gives its result two cycles after acceptance. An add whose entry is two cycles computes the sum in two parts: bits 15..0 with their carry first, then bits 31..16. The final 32-bit sum is exact, including a carry across bit 16 and wrap-around at bit 31.
- R2: In low-power mode, an operation whose table entry is one cycle shows its result in the cycle right after the acceptance edge, provided no older result is still pending.
- R3: In high-speed mode (`lowPower` = 0), every operation, including add, completes in one cycle whatever the table holds.
- R4: `inValid` is taken on every cycle with no stall. Results leave strictly in program order, one per cycle. When a one-cycle result meets an older two-cycle result, the younger one appears one cycle later. `outValid` is never high without a pending result.
- R5: After reset, the add entry is two cycles and every other entry is one cycle. An `errValid` pulse with opcode `errOp` sets that entry to two cycles. The new entry applies to operations accepted on later edges, not to one accepted on the same edge.
- R6: Table entries never decrease. A repeated error keeps an entry at two cycles. An error raised in high-speed mode still updates the table, but high-speed operations stay at one cycle.
- R7: Opcode encoding on `inOp` is 0 = add, 1 = AND, 2 = OR, 3 = XOR. The result is the 32-bit outcome of that operation on `inA` and `inB`.
- R8: While `rstN` is low, `outValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Decoded operation present this cycle |
| inOp | input | 2 | Opcode (0 add, 1 AND, 2 OR, 3 XOR) |
| inA | input | 32 | First operand |
| inB | input | 32 | Second operand |
| lowPower | input | 1 | 1 = table-driven split execute, 0 = single-stage execute |
| errValid | input | 1 | Timing error reported for opcode `errOp` |
| errOp | input | 2 | Opcode whose latency entry is raised |
| outValid | output | 1 | Result valid toward writeback |
| outResult | output | 32 | Result toward writeback |

## Verification
The assertions check these rules on every cycle:
- A split add always reaches the second register on the next edge.
- Any high-speed operation yields a valid output one cycle later.
- A held result is followed by another output, and the second register drains once the first one is empty.
- Latency entries rise on an error and never fall.

Some properties can only be shown by the bench's scenarios, because they depend on the full history of inputs. These are:
- exact sums across the half boundary;
- the exact cycle in which each result appears after mixed long/short sequences and mode changes;
- the fact that an error does not affect an operation accepted on the same edge.

// File: rtl/exec_pkg.sv
package exec_pkg;
  localparam int OP_W    = 2;
  localparam int NUM_OPS = 1 << OP_W;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 2'd0,
    OP_AND = 2'd1,
    OP_OR  = 2'd2,
    OP_XOR = 2'd3
  } opcode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic ex1Load;     // capture a new operation into the first register
    logic ex1Split;    // the captured operation is a two-part add
    logic ex2Load;     // move the first register into the second register
    logic outFromEx2;  // writeback takes the second register, else the bypass
  } exStrobe_t;
endpackage

// File: rtl/exec_ctrl.sv
module exec_ctrl
  import exec_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [OP_W-1:0] inOp,
  input  logic            lowPower,
  input  logic            errValid,
  input  logic [OP_W-1:0] errOp,
  output logic            outValid,
  output exStrobe_t       strobe
);
  // One bit per opcode: 1 = needs two execute cycles
  logic latTbl [NUM_OPS];

  for (genvar gi = 0; gi < NUM_OPS; gi++) begin : g_tbl
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        latTbl[gi] <= (gi == int'(OP_ADD));
      else if (errValid && errOp == OP_W'(gi))
        latTbl[gi] <= 1'b1;
    end

    AST_ERR_RAISES: assert property (@(posedge clk) disable iff (!rstN)
      (errValid && errOp == OP_W'(gi)) |=> latTbl[gi]);  // R5
    AST_TBL_MONOTONIC: assert property (@(posedge clk) disable iff (!rstN)
      latTbl[gi] |=> latTbl[gi]);                          // R6
  end

  // Predecode: latency lookup as the operation enters execute
  logic predLong;
  logic isAdd;
  always_comb begin
    predLong = lowPower && latTbl[inOp];
    isAdd    = (inOp == OP_ADD);
  end

  logic ex1Valid;
  logic ex1Long;
  logic ex2Valid;
  logic ex1Ready;
  logic ex2Load;

  always_comb begin
    ex1Ready = ex1Valid && !ex1Long;
    // A long op always advances; a short one only when an older result blocks the bypass
    ex2Load  = ex1Valid && (ex1Long || ex2Valid);
    outValid = ex2Valid || ex1Ready;

    strobe.ex1Load    = inValid;
    strobe.ex1Split   = predLong && isAdd;
    strobe.ex2Load    = ex2Load;
    strobe.outFromEx2 = ex2Valid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ex1Valid <= 1'b0;
      ex1Long  <= 1'b0;
      ex2Valid <= 1'b0;
    end else begin
      ex1Valid <= inValid;
      ex1Long  <= inValid && predLong;
      ex2Valid <= ex2Load;
    end
  end

  AST_HS_ONE_STAGE: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !lowPower) |=> outValid);                   // R3
  AST_HOLD_KEEPS_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (ex2Valid && ex1Valid) |=> (ex2Valid && outValid));     // R4
  AST_EX2_DRAINS: assert property (@(posedge clk) disable iff (!rstN)
    (ex2Valid && !ex1Valid) |=> !ex2Valid);                 // R4
endmodule

// File: rtl/exec_dp.sv
module exec_dp
  import exec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  exStrobe_t         strobe,
  input  logic [OP_W-1:0]   inOp,
  input  logic [DATA_W-1:0] inA,
  input  logic [DATA_W-1:0] inB,
  output logic [DATA_W-1:0] outResult
);
  localparam int HALF = DATA_W / 2;
  localparam int HI_W = DATA_W - HALF;

  logic [DATA_W-1:0] fullRes;
  logic [HALF:0]     loSum;
  logic [HI_W-1:0]   hiSum;

  logic [DATA_W-1:0] ex1Res;
  logic              ex1Carry;
  logic              ex1Split;
  logic [HI_W-1:0]   ex1AHi;
  logic [HI_W-1:0]   ex1BHi;
  logic [DATA_W-1:0] ex2Res;

  // First phase: whole result for short ops, lower half-sum for split adds
  always_comb begin
    case (opcode_e'(inOp))
      OP_ADD:  fullRes = inA + inB;
      OP_AND:  fullRes = inA & inB;
      OP_OR:   fullRes = inA | inB;
      default: fullRes = inA ^ inB;
    endcase
    loSum = {1'b0, inA[HALF-1:0]} + {1'b0, inB[HALF-1:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ex1Res   <= '0;
      ex1Carry <= 1'b0;
      ex1Split <= 1'b0;
      ex1AHi   <= '0;
      ex1BHi   <= '0;
    end else if (strobe.ex1Load) begin
      ex1Split <= strobe.ex1Split;
      ex1AHi   <= inA[DATA_W-1:HALF];
      ex1BHi   <= inB[DATA_W-1:HALF];
      if (strobe.ex1Split) begin
        ex1Res   <= {{HI_W{1'b0}}, loSum[HALF-1:0]};
        ex1Carry <= loSum[HALF];
      end else begin
        ex1Res   <= fullRes;
        ex1Carry <= 1'b0;
      end
    end
  end

  // Second phase: upper half-sum with the registered carry
  always_comb hiSum = ex1AHi + ex1BHi + {{(HI_W-1){1'b0}}, ex1Carry};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      ex2Res <= '0;
    else if (strobe.ex2Load)
      ex2Res <= ex1Split ? {hiSum, ex1Res[HALF-1:0]} : ex1Res;
  end

  always_comb outResult = strobe.outFromEx2 ? ex2Res : ex1Res;

  AST_SPLIT_JOINS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ex1Load && strobe.ex1Split) |=> strobe.ex2Load);  // R1
endmodule

// File: rtl/exec_stage.sv
module exec_stage
  import exec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        inOp,
  input  logic [DATA_W-1:0] inA,
  input  logic [DATA_W-1:0] inB,
  input  logic              lowPower,
  input  logic              errValid,
  input  logic [1:0]        errOp,
  output logic              outValid,
  output logic [DATA_W-1:0] outResult
);
  exStrobe_t strobe;

  exec_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inOp     (inOp),
    .lowPower (lowPower),
    .errValid (errValid),
    .errOp    (errOp),
    .outValid (outValid),
    .strobe   (strobe)
  );

  exec_dp #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .inOp      (inOp),
    .inA       (inA),
    .inB       (inB),
    .outResult (outResult)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) !rstN |-> !outValid);  // R8
endmodule

// File: tb/sim_exec_stage.sv
`timescale 1ns/1ps
module sim_exec_stage;
  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [1:0]  inOp;
  logic [31:0] inA;
  logic [31:0] inB;
  logic        lowPower;
  logic        errValid;
  logic [1:0]  errOp;
  logic        outValid;
  logic [31:0] outResult;

  always #2 clk = ~clk;

  exec_stage u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inOp(inOp), .inA(inA), .inB(inB),
    .lowPower(lowPower), .errValid(errValid), .errOp(errOp),
    .outValid(outValid), .outResult(outResult)
  );

  int nChecks = 0;
  int nErrors = 0;
  int edgeIdx = 0;
  int lastOut = -1;
  bit bTbl [4];
  logic [31:0] qRes [8192];
  int          qAt  [8192];
  string       qTag [8192];
  int qHead = 0;
  int qTail = 0;
  string tagOverride = "";
  logic [31:0] seed = 32'h1234_5678;

  function automatic logic [31:0] nextRand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  // R7: opcode encoding 0 add, 1 AND, 2 OR, 3 XOR
  function automatic logic [31:0] refOp(input logic [1:0] op, input logic [31:0] a, b);
    case (op)
      2'd0: return a + b;
      2'd1: return a & b;
      2'd2: return a | b;
      default: return a ^ b;
    endcase
  endfunction

  task automatic checkOut();
    nChecks++;
    if (qHead != qTail && qAt[qHead % 8192] == edgeIdx) begin
      if (outValid !== 1'b1 || outResult !== qRes[qHead % 8192]) begin
        nErrors++;
        $display("FAIL %s/R7 cycle %0d: actual valid=%b res=%h expected valid=1 res=%h",
                 qTag[qHead % 8192], edgeIdx, outValid, outResult, qRes[qHead % 8192]);
      end
      qHead++;
    end else if (outValid !== 1'b0) begin
      nErrors++;
      $display("FAIL R4 cycle %0d: actual valid=%b expected valid=0", edgeIdx, outValid);
    end
  endtask

  task automatic step(input bit v, input logic [1:0] op, input logic [31:0] a, b,
                      input bit lp, input bit ev, input logic [1:0] eo);
    int nat;
    int at;
    bit lng;
    string tg;
    inValid = v; inOp = op; inA = a; inB = b; lowPower = lp; errValid = ev; errOp = eo;
    if (v) begin
      lng = lp && bTbl[op];
      nat = edgeIdx + 1 + (lng ? 1 : 0);
      at  = (nat > lastOut) ? nat : lastOut + 1;
      if (at > nat)            tg = "R4";
      else if (tagOverride != "") tg = tagOverride;
      else if (!lp)            tg = "R3";
      else if (lng && op == 2'd0) tg = "R1";
      else if (lng)            tg = "R5";
      else                     tg = "R2";
      qRes[qTail % 8192] = refOp(op, a, b);
      qAt[qTail % 8192]  = at;
      qTag[qTail % 8192] = tg;
      qTail++;
      lastOut = at;
    end
    if (ev) bTbl[eo] = 1'b1;  // applies to later edges only (R5)
    @(posedge clk);
    edgeIdx++;
    @(negedge clk);
    checkOut();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 2'd0, 32'd0, 32'd0, lowPower, 0, 2'd0);
  endtask

  function automatic logic [31:0] patA(input int p);
    case (p)
      0: return 32'h0000_FFFF;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_8000;
      3: return 32'h0000_0000;
      default: return nextRand();
    endcase
  endfunction

  function automatic logic [31:0] patB(input int p);
    case (p)
      0: return 32'h0000_0001;
      1: return 32'h0000_0001;
      2: return 32'h8000_8000;
      3: return 32'hFFFF_FFFF;
      default: return nextRand();
    endcase
  endfunction

  // Each opcode over the operand patterns, with a gap after each op
  task automatic sweepGap(input bit lp);
    for (int op = 0; op < 4; op++)
      for (int p = 0; p < 8; p++) begin
        step(1, 2'(op), patA(p), patB(p), lp, 0, 2'd0);
        step(0, 2'd0, 32'd0, 32'd0, lp, 0, 2'd0);
      end
  endtask

  // Every ordered pair of opcodes issued back to back
  task automatic sweepPairs(input bit lp);
    for (int o1 = 0; o1 < 4; o1++)
      for (int o2 = 0; o2 < 4; o2++) begin
        step(1, 2'(o1), nextRand(), nextRand(), lp, 0, 2'd0);
        step(1, 2'(o2), nextRand(), nextRand(), lp, 0, 2'd0);
        step(0, 2'd0, 32'd0, 32'd0, lp, 0, 2'd0);
      end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErrors++;
    $display("FAIL R4 watchdog: actual run still going, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    rstN = 1'b0; inValid = 1'b0; inOp = 2'd0; inA = '0; inB = '0;
    lowPower = 1'b1; errValid = 1'b0; errOp = 2'd0;
    bTbl[0] = 1'b1; bTbl[1] = 1'b0; bTbl[2] = 1'b0; bTbl[3] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    nChecks++;
    if (outValid !== 1'b0) begin
      nErrors++;
      $display("FAIL R8 reset: actual valid=%b expected 0", outValid);
    end
    rstN = 1'b1;

    // Reset-state table: add long, logic short (R1, R2, R5)
    sweepGap(1);
    sweepPairs(1);
    // High-speed mode: everything one cycle (R3)
    sweepGap(0);
    sweepPairs(0);
    // Error on AND: same-edge op still short, later ANDs long (R5)
    step(1, 2'd1, 32'hF0F0_F0F0, 32'hFF00_FF00, 1, 1, 2'd1);
    step(1, 2'd1, 32'hF0F0_F0F0, 32'h0FF0_0FF0, 1, 0, 2'd0);
    idle(2);
    sweepPairs(1);
    // Errors raised in high-speed mode, AND again (R6)
    tagOverride = "R6";
    step(0, 2'd0, 32'd0, 32'd0, 0, 1, 2'd1);
    step(0, 2'd0, 32'd0, 32'd0, 0, 1, 2'd3);
    sweepGap(0);
    sweepGap(1);
    tagOverride = "";
    idle(2);
    // Mixed traffic with mode changes and occasional errors
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = nextRand();
      if (r[9:4] == 6'd0) lowPower = ~lowPower;
      step(r[1:0] != 2'b00, r[3:2], nextRand(), nextRand(), lowPower,
           r[17:12] == 6'd7, r[19:18]);
    end
    idle(5);
    nChecks++;
    if (qHead != qTail) begin
      nErrors++;
      $display("FAIL R4 drain: actual %0d results missing, expected 0", qTail - qHead);
    end
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule